// File: doc/BRIEF.md
# Debug Exception Trap Filter

This block sits beside a processor's exception logic and decides, for every exception the core is about to take, whether a debugger should take control instead. The core presents an exception-type code together with a one-cycle valid strobe. A stop-select mask has one enable bit per exception class. In the same cycle, the block answers with an intercept flag.

When an exception is intercepted, the bit for its class is ORed into a sticky reason register on the next clock edge. Bits that were already set stay set. A stall request is also updated on that edge. It goes high after an intercepted exception and low after an exception that was not intercepted. It keeps its level while no exception is presented. Debug software reads the reason register to learn why the core stopped. Software can overwrite the register through a write port, which is how it clears it.

Top module: `dbg_trap_filter`

## Requirements
- R1: Exception codes 0 to 12 select class bits 0 to 12 of both the stop-select mask and the reason register, in this order: 0 reset, 1 bus error, 2 data page fault, 3 instruction page fault, 4 tick timer, 5 alignment, 6 illegal instruction, 7 external interrupt, 8 data TLB miss, 9 instruction TLB miss, 10 range, 11 system call, 12 trap.
- R2: `intercept` is high in the same cycle as `exc_valid` exactly when the code is in 0 to 12 and the mask bit of its class is set. No clock edge lies on this path.
- R3: `intercept` is low in every cycle where `exc_valid` is low, whatever the code and the mask.
- R4: Codes 13, 14 and 15 are never intercepted, even with every mask bit set. They leave `reason` unchanged.
- R5: After an intercepted exception, `reason` at the next edge equals its previous value ORed with the class bit. No bit that was already set is cleared.
- R6: An exception that is not intercepted, or a cycle with no exception, leaves `reason` unchanged unless the write port is used.
- R7: On the edge after a valid exception, `stall_req` takes the value `intercept` had in that cycle. When `exc_valid` is low, `stall_req` holds its value.
- R8: When `reason_wr_en` is high, `reason` loads `reason_wr_data` on the next edge. A class bit intercepted in the same cycle is ORed onto the written value, so the event is not lost.
- R9: Synchronous active-high reset clears `reason` and `stall_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | An exception is being taken this cycle |
| exc_code | input | 4 | Exception class code |
| stop_mask | input | 13 | Per-class intercept enable |
| reason_wr_en | input | 1 | Load the reason register |
| reason_wr_data | input | 13 | Value to load into the reason register |
| intercept | output | 1 | Debugger takes this exception (combinational) |
| stall_req | output | 1 | Stall request to the core |
| reason | output | 13 | Sticky record of the intercepted classes |

## Verification
The hardest case to reach is a software write colliding with an intercepted exception in the same cycle. In that cycle the write and the accumulation both claim the register. The stimulus raises `reason_wr_en` together with `exc_valid`, using a class whose bit is absent from the written value. It then checks that the register holds exactly the written value plus that one bit. A second case holds the strobe low after an intercept while the code and mask still select an enabled class. This shows that the stall level persists and that no spurious intercept appears.

// File: rtl/dbg_trap_pkg.sv
`timescale 1ns/1ps
package dbg_trap_pkg;

    localparam int NUM_CLASSES = 13;
    localparam int CODE_W      = 4;

    typedef enum logic [CODE_W-1:0] {
        EXC_RESET    = 4'd0,
        EXC_BUSERR   = 4'd1,
        EXC_DPAGE    = 4'd2,
        EXC_IPAGE    = 4'd3,
        EXC_TICK     = 4'd4,
        EXC_ALIGN    = 4'd5,
        EXC_ILLEGAL  = 4'd6,
        EXC_EXTINT   = 4'd7,
        EXC_DTLBMISS = 4'd8,
        EXC_ITLBMISS = 4'd9,
        EXC_RANGE    = 4'd10,
        EXC_SYSCALL  = 4'd11,
        EXC_TRAP     = 4'd12
    } exc_class_e;

    typedef logic [NUM_CLASSES-1:0] class_vec_t;

    typedef struct packed {
        logic       valid;
        class_vec_t hit;
    } trap_event_t;

    function automatic logic code_in_range(input logic [CODE_W-1:0] code);
        return int'(code) < NUM_CLASSES;
    endfunction

endpackage

// File: rtl/trap_class_decode.sv
`timescale 1ns/1ps
module trap_class_decode #(
    parameter int NCLS  = dbg_trap_pkg::NUM_CLASSES,
    parameter int CW    = dbg_trap_pkg::CODE_W
) (
    input  logic            valid,
    input  logic [CW-1:0]   code,
    input  logic [NCLS-1:0] enable,
    output logic [NCLS-1:0] hit
);
    // One comparator per class; codes beyond NCLS-1 match no slot.
    for (genvar g = 0; g < NCLS; g++) begin : g_slot
        assign hit[g] = valid && (code == CW'(g)) && enable[g];
    end
endmodule

// File: rtl/trap_reason_reg.sv
`timescale 1ns/1ps
module trap_reason_reg #(
    parameter int NCLS = dbg_trap_pkg::NUM_CLASSES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [NCLS-1:0] wr_data,
    input  logic [NCLS-1:0] set_bits,
    output logic [NCLS-1:0] value
);
    logic [NCLS-1:0] base;

    always_comb base = wr_en ? wr_data : value;

    always_ff @(posedge clk) begin
        if (rst) value <= '0;
        else     value <= base | set_bits;
    end
endmodule

// File: rtl/trap_stall_reg.sv
`timescale 1ns/1ps
module trap_stall_reg (
    input  logic clk,
    input  logic rst,
    input  logic update,
    input  logic level,
    output logic stall
);
    always_ff @(posedge clk) begin
        if (rst)         stall <= 1'b0;
        else if (update) stall <= level;
    end
endmodule

// File: rtl/dbg_trap_filter.sv
`timescale 1ns/1ps
module dbg_trap_filter #(
    parameter int NUM_CLASSES = dbg_trap_pkg::NUM_CLASSES,
    parameter int CODE_W      = dbg_trap_pkg::CODE_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   exc_valid,
    input  logic [CODE_W-1:0]      exc_code,
    input  logic [NUM_CLASSES-1:0] stop_mask,
    input  logic                   reason_wr_en,
    input  logic [NUM_CLASSES-1:0] reason_wr_data,
    output logic                   intercept,
    output logic                   stall_req,
    output logic [NUM_CLASSES-1:0] reason
);
    typedef struct packed {
        logic                   valid;
        logic [NUM_CLASSES-1:0] hit;
    } evt_t;

    evt_t evt;

    trap_class_decode #(.NCLS(NUM_CLASSES), .CW(CODE_W)) u_decode (
        .valid  (exc_valid),
        .code   (exc_code),
        .enable (stop_mask),
        .hit    (evt.hit)
    );

    assign evt.valid = exc_valid;
    assign intercept = |evt.hit;

    trap_reason_reg #(.NCLS(NUM_CLASSES)) u_reason (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reason_wr_en),
        .wr_data  (reason_wr_data),
        .set_bits (evt.hit),
        .value    (reason)
    );

    trap_stall_reg u_stall (
        .clk    (clk),
        .rst    (rst),
        .update (evt.valid),
        .level  (intercept),
        .stall  (stall_req)
    );
endmodule

// File: rtl/dbg_trap_filter_chk.sv
`timescale 1ns/1ps
module dbg_trap_filter_chk #(
    parameter int NUM_CLASSES = dbg_trap_pkg::NUM_CLASSES,
    parameter int CODE_W      = dbg_trap_pkg::CODE_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   exc_valid,
    input logic [CODE_W-1:0]      exc_code,
    input logic [NUM_CLASSES-1:0] stop_mask,
    input logic                   reason_wr_en,
    input logic [NUM_CLASSES-1:0] reason_wr_data,
    input logic                   intercept,
    input logic                   stall_req,
    input logic [NUM_CLASSES-1:0] reason
);
    AST_IDLE_NO_INTERCEPT: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |-> !intercept); // R3

    AST_RANGE_NO_INTERCEPT: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && int'(exc_code) >= NUM_CLASSES) |-> !intercept); // R4

    AST_INTERCEPT_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
        intercept |=> ((reason >> $past(exc_code)) & NUM_CLASSES'(1)) != '0); // R5

    AST_REASON_STICKY: assert property (@(posedge clk) disable iff (rst)
        !reason_wr_en |=> (reason & $past(reason)) == $past(reason)); // R5

    AST_REASON_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!reason_wr_en && !intercept) |=> $stable(reason)); // R6

    AST_STALL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> stall_req == $past(intercept)); // R7

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !exc_valid |=> $stable(stall_req)); // R7

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
        reason_wr_en |=> (reason & $past(reason_wr_data)) == $past(reason_wr_data)); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (reason == '0 && !stall_req)); // R9
endmodule

bind dbg_trap_filter dbg_trap_filter_chk #(
    .NUM_CLASSES(NUM_CLASSES),
    .CODE_W(CODE_W)
) u_chk (.*);

// File: tb/dbg_trap_filter_bench.sv
`timescale 1ns/1ps
module dbg_trap_filter_bench;
    localparam int N  = dbg_trap_pkg::NUM_CLASSES;
    localparam int CW = dbg_trap_pkg::CODE_W;

    logic          clk = 1'b0;
    logic          rst;
    logic          exc_valid;
    logic [CW-1:0] exc_code;
    logic [N-1:0]  stop_mask;
    logic          reason_wr_en;
    logic [N-1:0]  reason_wr_data;
    logic          intercept;
    logic          stall_req;
    logic [N-1:0]  reason;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [N-1:0] exp_reason;
    logic         exp_stall;

    always #2.5 clk = ~clk;

    dbg_trap_filter u_dbg_trap_filter (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_code(exc_code),
        .stop_mask(stop_mask), .reason_wr_en(reason_wr_en),
        .reason_wr_data(reason_wr_data), .intercept(intercept),
        .stall_req(stall_req), .reason(reason)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic model_hit(input logic [CW-1:0] c, input logic [N-1:0] m);
        return (int'(c) < N) && m[c];
    endfunction

    // One exception cycle: drive at negedge, check intercept, then state after the edge.
    task automatic exc(input logic [CW-1:0] c, input string req);
        logic h;
        @(negedge clk);
        exc_valid = 1'b1;
        exc_code  = c;
        h = model_hit(c, stop_mask);
        #1 chk({req, " intercept"}, 32'(intercept), 32'(h));
        if (h) exp_reason = exp_reason | (N'(1) << c);
        exp_stall = h;
        @(negedge clk);
        exc_valid = 1'b0;
        chk({req, " reason"}, 32'(reason), 32'(exp_reason));
        chk({req, " stall"}, 32'(stall_req), 32'(exp_stall));
    endtask

    task automatic write_reason(input logic [N-1:0] v);
        @(negedge clk);
        reason_wr_en   = 1'b1;
        reason_wr_data = v;
        @(negedge clk);
        reason_wr_en = 1'b0;
        exp_reason   = v;
        chk("R8 write", 32'(reason), 32'(v));
    endtask

    task automatic t_reset();
        rst = 1'b1; exc_valid = 1'b0; exc_code = '0; stop_mask = '0;
        reason_wr_en = 1'b0; reason_wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_reason = '0; exp_stall = 1'b0;
        chk("R9 reason", 32'(reason), 0);
        chk("R9 stall", 32'(stall_req), 0);
        chk("R3 intercept idle", 32'(intercept), 0);
    endtask

    task automatic t_walk_all();
        stop_mask = '1;
        for (int i = 0; i < N; i++) exc(CW'(i), "R1 R2 R5 walk");
        chk("R5 all classes", 32'(reason), 32'((1 << N) - 1));
        write_reason('0);
    endtask

    task automatic t_masked();
        stop_mask = N'(1) << dbg_trap_pkg::EXC_IPAGE;
        exc(dbg_trap_pkg::EXC_IPAGE, "R2 enabled class");
        exc(dbg_trap_pkg::EXC_ALIGN, "R6 R7 disabled class");
        exc(dbg_trap_pkg::EXC_TRAP, "R6 disabled trap");
        stop_mask = N'(1) << dbg_trap_pkg::EXC_SYSCALL;
        exc(dbg_trap_pkg::EXC_SYSCALL, "R5 sticky accumulate");
    endtask

    task automatic t_out_of_range();
        stop_mask = '1;
        exc(dbg_trap_pkg::EXC_TICK, "R2 before range");
        for (int c = N; c < (1 << CW); c++) exc(CW'(c), "R4 out of range");
    endtask

    task automatic t_idle_hold();
        stop_mask = '1;
        exc(dbg_trap_pkg::EXC_RANGE, "R7 set stall");
        @(negedge clk);
        exc_code = dbg_trap_pkg::EXC_RANGE;
        #1 chk("R3 no strobe", 32'(intercept), 0);
        repeat (3) @(negedge clk);
        chk("R7 stall holds", 32'(stall_req), 1);
        chk("R6 reason idle", 32'(reason), 32'(exp_reason));
    endtask

    task automatic t_write_collide();
        stop_mask = '1;
        write_reason(N'(13'h0A5));
        @(negedge clk);
        reason_wr_en   = 1'b1;
        reason_wr_data = N'(13'h100);
        exc_valid      = 1'b1;
        exc_code       = dbg_trap_pkg::EXC_BUSERR;
        #1 chk("R8 collide intercept", 32'(intercept), 1);
        @(negedge clk);
        reason_wr_en = 1'b0;
        exc_valid    = 1'b0;
        exp_reason   = N'(13'h102);
        chk("R8 collide reason", 32'(reason), 32'(exp_reason));
        write_reason('0);
        chk("R8 cleared", 32'(reason), 0);
    endtask

    initial begin
        t_reset();
        t_walk_all();
        t_masked();
        t_out_of_range();
        t_idle_hold();
        t_write_collide();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule